// File: doc/BRIEF.md
# Accumulator Processor Fetch-Execute Sequencer

This block is the control unit and datapath of a small stored-program processor built around a single accumulator. Program words and data words sit in the same external read-write memory and are reached only by their location. Every memory access is made as an explicit register transfer. The address register (MAR) drives the memory address pins, and the buffer register (MBR) receives read data and supplies write data. The block also holds the program counter (PC), the instruction register (IR) and the accumulator (ACC).

Each instruction runs in two phases. The fetch phase reads the word at PC, places it in IR and advances PC by one. The execute phase then performs one of three operations: load a word into ACC, store ACC to a location, or add a word into ACC. Opcode zero, or any opcode the block does not know, stops the sequencer. The external memory is a plain synchronous RAM with one cycle of read latency.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, PC, IR, MAR, MBR and ACC are cleared to zero, `halted` is deasserted and the sequencer restarts at the first fetch step. After that edge, `mem_addr`, `mem_wdata` and `mem_we` read zero.
- R2: A fetch takes four cycles. In the first, MAR is loaded from PC. In the second and third, `mem_addr` shows PC while the read completes, and MBR captures `mem_rdata` at the end of the third. In the fourth, IR is loaded from MBR.
- R3: PC advances by exactly one, modulo 2^12, in the cycle that loads IR, and it never changes at any other time. Instructions therefore run in address order.
- R4: LOAD (opcode 1) puts the address field into MAR, waits one cycle for the read, captures the word into MBR and then copies MBR into ACC.
- R5: STORE (opcode 2) puts the address field into MAR, copies ACC into MBR, and then asserts `mem_we` for exactly one cycle with `mem_addr` equal to the address field and `mem_wdata` equal to ACC.
- R6: ADD (opcode 3) reads the addressed word into MBR in the same way as LOAD and then replaces ACC with ACC + MBR modulo 2^16. No carry is kept.
- R7: Opcode 0, and every opcode from 4 to 15, makes the sequencer stop in the decode step. From then on `halted` stays high, `mem_we` stays low and `mem_addr` does not change until reset.
- R8: An instruction word is 16 bits. Bits [15:12] hold the opcode and bits [11:0] hold the memory address.
- R9: Instructions and data share one memory. A word written by STORE is executed as an instruction if PC later reaches its location.
- R10: Counted from one fetch start to the next, LOAD and ADD take 8 cycles and STORE takes 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory address, always the content of MAR |
| mem_wdata | output | 16 | Memory write data, always the content of MBR |
| mem_we | output | 1 | Memory write enable, one cycle per STORE |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once the sequencer has stopped |

## Verification
The hardest case to reach is a program that rewrites itself. A STORE must land in a location that a later fetch picks up, so the written word has to be built in the accumulator from data that LOAD and ADD brought in first. The bench reaches this with a short program: it loads a STORE instruction word from data, writes it over a later HALT slot, runs an ADD, and then lets PC reach the rewritten slot. Two other programs cover the remaining corners. One wraps the addition past 0xFFFF and stores to the top address. The other places an unknown opcode ahead of a STORE, and the bench confirms that the STORE never reaches memory.

// File: rtl/acc_cpu_pkg.sv
// Shared constants and types for the accumulator processor.
// Assumes a fixed 4-bit opcode at the top of each instruction word.
package acc_cpu_pkg;

    localparam int OPW = 4;

    localparam logic [OPW-1:0] OPC_HALT  = 4'd0;
    localparam logic [OPW-1:0] OPC_LOAD  = 4'd1;
    localparam logic [OPW-1:0] OPC_STORE = 4'd2;
    localparam logic [OPW-1:0] OPC_ADD   = 4'd3;

    // One state per register-transfer step
    typedef enum logic [3:0] {
        ST_FADR  = 4'd0,   // MAR <- PC
        ST_FWAIT = 4'd1,   // memory read in flight
        ST_FCAP  = 4'd2,   // MBR <- memory
        ST_FIR   = 4'd3,   // IR <- MBR, PC <- PC+1
        ST_DEC   = 4'd4,   // MAR <- IR address field, or stop
        ST_RWAIT = 4'd5,   // operand read in flight
        ST_RCAP  = 4'd6,   // MBR <- memory
        ST_LOAD  = 4'd7,   // ACC <- MBR
        ST_ADD   = 4'd8,   // ACC <- ACC + MBR
        ST_SMBR  = 4'd9,   // MBR <- ACC
        ST_WRITE = 4'd10,  // memory[MAR] <- MBR
        ST_HALT  = 4'd11   // stopped until reset
    } seq_state_e;

    // Register-load strobes from the sequencer to the datapath
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic ir_load;
        logic pc_inc;
        logic acc_load;
        logic acc_add;
    } dp_ctl_t;

endpackage

// File: rtl/acc_cpu_ctrl.sv
// Sequencer for the fetch and execute phases.
// Walks one register transfer per cycle and emits datapath strobes.
// Assumes the opcode input comes from IR, which is stable from ST_DEC
// until the next fetch loads IR again.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    output dp_ctl_t        ctl,
    output logic           mem_we,
    output logic           halted
);

    seq_state_e state_q, state_d;
    logic       op_known;

    // Only LOAD, STORE and ADD are executable
    always_comb begin
        op_known = (opcode == OPC_LOAD) || (opcode == OPC_STORE) || (opcode == OPC_ADD);
    end

    // State register, restarted at the fetch step by reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FADR;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FADR:  state_d = ST_FWAIT;
            ST_FWAIT: state_d = ST_FCAP;
            ST_FCAP:  state_d = ST_FIR;
            ST_FIR:   state_d = ST_DEC;
            ST_DEC: begin
                if (!op_known)                state_d = ST_HALT;
                else if (opcode == OPC_STORE) state_d = ST_SMBR;
                else                          state_d = ST_RWAIT;
            end
            ST_RWAIT: state_d = ST_RCAP;
            ST_RCAP:  state_d = (opcode == OPC_LOAD) ? ST_LOAD : ST_ADD;
            ST_LOAD:  state_d = ST_FADR;
            ST_ADD:   state_d = ST_FADR;
            ST_SMBR:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_FADR;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // Strobe decode for the current step
    always_comb begin
        ctl              = '0;
        ctl.mar_from_pc  = (state_q == ST_FADR);
        ctl.mar_from_ir  = (state_q == ST_DEC) && op_known;
        ctl.mbr_from_mem = (state_q == ST_FCAP) || (state_q == ST_RCAP);
        ctl.mbr_from_acc = (state_q == ST_SMBR);
        ctl.ir_load      = (state_q == ST_FIR);
        ctl.pc_inc       = (state_q == ST_FIR);
        ctl.acc_load     = (state_q == ST_LOAD);
        ctl.acc_add      = (state_q == ST_ADD);
        mem_we           = (state_q == ST_WRITE);
        halted           = (state_q == ST_HALT);
    end

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7
    halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R10
    store_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ctl.mar_from_pc);

endmodule

// File: rtl/acc_cpu_dp.sv
// Register file of the accumulator processor: PC, IR, MAR, MBR, ACC.
// Each register loads only on its strobe. MAR drives the memory address
// and MBR drives the write data, so every access goes through them.
// Assumes mem_rdata holds the word addressed by MAR one cycle earlier.
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int ADDR_W = DATA_W - OPW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dp_ctl_t           ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OPW-1:0]    opcode
);

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mbr_q;
    logic [DATA_W-1:0] acc_q;

    // Program counter: steps by one after each instruction fetch
    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= '0;
        else if (ctl.pc_inc) pc_q <= pc_q + ADDR_W'(1);
    end

    // Instruction register: takes the fetched word from MBR
    always_ff @(posedge clk) begin
        if (!rst_n)           ir_q <= '0;
        else if (ctl.ir_load) ir_q <= mbr_q;
    end

    // Address register: PC during fetch, address field during execute
    always_ff @(posedge clk) begin
        if (!rst_n)               mar_q <= '0;
        else if (ctl.mar_from_pc) mar_q <= pc_q;
        else if (ctl.mar_from_ir) mar_q <= ir_q[ADDR_W-1:0];
    end

    // Buffer register: read data from memory, or ACC for a store
    always_ff @(posedge clk) begin
        if (!rst_n)                mbr_q <= '0;
        else if (ctl.mbr_from_mem) mbr_q <= mem_rdata;
        else if (ctl.mbr_from_acc) mbr_q <= acc_q;
    end

    // Accumulator: copy of MBR or wrapping sum with MBR
    always_ff @(posedge clk) begin
        if (!rst_n)            acc_q <= '0;
        else if (ctl.acc_load) acc_q <= mbr_q;
        else if (ctl.acc_add)  acc_q <= acc_q + mbr_q;
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign opcode    = ir_q[DATA_W-1 -: OPW];

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> pc_q == ADDR_W'($past(pc_q) + ADDR_W'(1)));

    // R3
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.pc_inc |=> $stable(pc_q));

    // R4
    acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.acc_load |=> acc_q == $past(mbr_q));

    // R6
    acc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.acc_add |=> acc_q == DATA_W'($past(acc_q) + $past(mbr_q)));

    // R5
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mbr_from_acc |=> mbr_q == $past(acc_q));

endmodule

// File: rtl/acc_cpu.sv
// Top of the accumulator processor: sequencer plus register datapath.
// Connects to one synchronous single-port RAM with one cycle of read
// latency, which holds both program and data.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int ADDR_W = DATA_W - OPW
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    dp_ctl_t        ctl;
    logic [OPW-1:0] opcode;

    acc_cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .ctl    (ctl),
        .mem_we (mem_we),
        .halted (halted)
    );

    acc_cpu_dp #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode)
    );

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7
    halt_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr));

endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        halted;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    acc_cpu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // Shared program/data RAM, synchronous read
    logic [15:0] ram [4096];
    logic [15:0] ref_ram [4096];

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    typedef struct {
        logic [11:0] a;
        logic [15:0] w;
        logic        we;
        logic        h;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic push(input logic [11:0] a, input logic [15:0] w,
                        input logic we, input logic h, input string tag);
        exp_t e;
        e.a = a; e.w = w; e.we = we; e.h = h; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Behavioural model: interprets the program and lists the expected
    // port values for every cycle (R2 R3 R4 R5 R6 R7 R8 R10)
    task automatic model_run(input int halt_cycles);
        logic [11:0] pc = '0;
        logic [15:0] acc = '0;
        logic [11:0] m = '0;
        logic [15:0] b = '0;
        logic [15:0] word;
        logic [3:0]  op;
        logic [11:0] fa;
        push(m, b, 0, 0, "R1 fetch start");
        for (int n = 0; n < 300; n++) begin
            word = ref_ram[pc];
            push(pc, b, 0, 0, "R3 fetch addr");
            push(pc, b, 0, 0, "R2 fetch wait");
            b = word;
            push(pc, b, 0, 0, "R2 fetch capture");
            push(pc, b, 0, 0, "R8 decode");
            op = word[15:12];
            fa = word[11:0];
            if (op == 4'd1 || op == 4'd3) begin
                m = fa;
                push(m, b, 0, 0, op == 4'd1 ? "R4 read wait" : "R6 read wait");
                push(m, b, 0, 0, op == 4'd1 ? "R4 read wait" : "R6 read wait");
                b = ref_ram[fa];
                push(m, b, 0, 0, op == 4'd1 ? "R4 capture" : "R6 capture");
                acc = (op == 4'd1) ? b : 16'(acc + b);
                push(m, b, 0, 0, "R10 next fetch");
            end else if (op == 4'd2) begin
                m = fa;
                push(m, b, 0, 0, "R5 buffer");
                b = acc;
                push(m, b, 1, 0, "R5 write");
                ref_ram[fa] = b;
                push(m, b, 0, 0, "R10 next fetch");
            end else begin
                for (int k = 0; k < halt_cycles; k++) push(pc, b, 0, 1, "R7 halted");
                break;
            end
            pc = pc + 12'd1;
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) begin
            ram[i] = 16'h0000;
            ref_ram[i] = 16'h0000;
        end
    endtask

    task automatic put(input int addr, input logic [15:0] val);
        ram[addr] = val;
        ref_ram[addr] = val;
    endtask

    task automatic check_ports(input exp_t e, input int cyc);
        checks++;
        if (mem_addr !== e.a || mem_we !== e.we || mem_wdata !== e.w || halted !== e.h) begin
            fails++;
            $display("FAIL %s cycle %0d: actual addr=%h we=%b wdata=%h halted=%b expected addr=%h we=%b wdata=%h halted=%b",
                     e.tag, cyc, mem_addr, mem_we, mem_wdata, halted, e.a, e.we, e.w, e.h);
        end
    endtask

    task automatic check_word(input string tag, input int addr, input logic [15:0] expv);
        checks++;
        if (ram[addr] !== expv) begin
            fails++;
            $display("FAIL %s mem[%h]: actual %h expected %h", tag, addr, ram[addr], expv);
        end
    endtask

    // Reset, run the program against the model, then compare memory
    task automatic run_prog(input string name);
        int cyc = 0;
        int bad = 0;
        int first_halt = -1;
        int model_halt = -1;
        exp_t e;
        exp_q.delete();
        model_run(6);
        for (int i = 0; i < exp_q.size(); i++)
            if (exp_q[i].h && model_halt < 0) model_halt = i;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state after a previous run (including a halted one)
        checks++;
        if (mem_addr !== 12'h0 || mem_wdata !== 16'h0 || mem_we !== 1'b0 || halted !== 1'b0) begin
            fails++;
            $display("FAIL R1 %s reset: actual addr=%h wdata=%h we=%b halted=%b expected 0 0 0 0",
                     name, mem_addr, mem_wdata, mem_we, halted);
        end
        rst_n = 1'b1;
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            if (halted === 1'b1 && first_halt < 0) first_halt = cyc;
            check_ports(e, cyc);
            cyc++;
            @(negedge clk);
        end
        // R10: total cycle count to the stop matches the timing model
        checks++;
        if (first_halt != model_halt) begin
            fails++;
            $display("FAIL R10 %s halt cycle: actual %0d expected %0d", name, first_halt, model_halt);
        end
        // R9: every memory word matches the model after the run
        checks++;
        for (int i = 0; i < 4096; i++) if (ram[i] !== ref_ram[i]) bad++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R9 %s memory image: actual %0d mismatching words expected 0", name, bad);
        end
    endtask

    initial begin
        // Basic LOAD, ADD, STORE, HALT
        clear_mem();
        put(0, 16'h1064); put(1, 16'h3065); put(2, 16'h2066); put(3, 16'h0000);
        put(100, 16'd5); put(101, 16'd7);
        run_prog("basic");
        check_word("R6 basic sum", 102, 16'd12);

        // Wrapping addition and store to the top address, unknown opcode stop
        clear_mem();
        put(0, 16'h10C8); put(1, 16'h30C9); put(2, 16'h20CA); put(3, 16'h2FFF); put(4, 16'hF123);
        put(200, 16'hFFFF); put(201, 16'h0003);
        run_prog("wrap");
        check_word("R6 wrapped sum", 16'h0CA, 16'h0002);
        check_word("R5 top address store", 16'hFFF, 16'h0002);

        // Unknown opcode before a STORE: the store must never happen
        clear_mem();
        put(0, 16'h1020); put(1, 16'h5030); put(2, 16'h2030);
        put(16'h020, 16'hABCD); put(16'h030, 16'h1111);
        run_prog("badop");
        check_word("R7 store after stop ignored", 16'h030, 16'h1111);

        // Self-modifying program through the shared memory
        clear_mem();
        put(0, 16'h100A); put(1, 16'h2003); put(2, 16'h300B); put(3, 16'h0000); put(4, 16'h0000);
        put(10, 16'h2014); put(11, 16'h0001);
        run_prog("selfmod");
        check_word("R9 patched instruction", 3, 16'h2014);
        check_word("R9 patched store result", 16'h014, 16'h2015);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule